// File: doc/BRIEF.md
# Fixed-Priority Forwarding Request Selector

This block sits between a register scoreboard and the four register-file clusters of a compute engine. Six requesters each present a candidate register that may have to be forwarded from the cluster that owns it to another cluster. The requesters are the load path, the B-cluster ALU, the A cluster, the C cluster, the B-cluster branch path and the store path. With each candidate the scoreboard supplies the register's ready and pending flags. A candidate is eligible only when the requester's valid bit, the ready flag and the pending flag are all set.

In every cycle the block takes up to four eligible candidates in fixed priority order and places them in four output slots. A slot carries a valid bit and the 9-bit register address, and the data itself is never handled here. The two top address bits decode into a one-hot strobe that tells the owning cluster to forward. Each granted requester also gets a strobe back so the scoreboard can clear that register's pending flag. The block keeps no state between decisions. A candidate that loses simply stays on its inputs and competes again in the next cycle. All outputs are registered, so they appear one clock after the inputs are sampled.

Top module: `fwdsel_top`

## Requirements
- R1: A requester is eligible only when its reqValid, reqReady and reqPending bits are all 1. If any of the three is 0, that requester is never granted.
- R2: No more than four requests are granted in any one cycle.
- R3: Requester index gives priority. Index 0 is load, 1 is the B-cluster ALU, 2 is the A cluster, 3 is the C cluster, 4 is the B-cluster branch path and 5 is store. Index 0 ranks highest. When more than four requesters are eligible, the four lowest-indexed eligible requesters win.
- R4: Slots fill from slot 0 upward in priority order with no gaps. Slot k holds the (k+1)-th granted requester, and slotValid is always of the form 0..01..1.
- R5: A valid slot carries the 9-bit register address presented by the requester it holds (bits [9k+8:9k] of slotAddr for slot k). An invalid slot carries address 0.
- R6: For slot k, slotCluster bits [4k+3:4k] are one-hot when the slot is valid. Bit k·4+c is set where c is address bits [8:7]: 0 is cluster A, 1 is B, 2 is C and 3 is M. The field is all zero when the slot is invalid.
- R7: pendClr[i] is 1 exactly when requester i was granted. The number of set pendClr bits equals the number of valid slots.
- R8: Each decision depends only on the inputs sampled in that cycle. An eligible requester that lost is granted in a later cycle once higher-priority eligible requesters drop out. When four or fewer requesters are eligible, all of them are granted.
- R9: Outputs are registered and show the decision for the inputs sampled at the previous rising clock edge. An active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 6 | Requester presents a candidate |
| reqReady | input | 6 | Scoreboard ready flag of each candidate register |
| reqPending | input | 6 | Scoreboard pending flag of each candidate register |
| reqAddr | input | 54 | Six 9-bit candidate register addresses, requester i at [9i+8:9i] |
| slotValid | output | 4 | Slot holds a granted forward |
| slotAddr | output | 36 | Four 9-bit forwarded register addresses |
| slotCluster | output | 16 | Per-slot one-hot strobe to the owning cluster |
| pendClr | output | 6 | Per-requester strobe that clears the pending flag |

## Verification
The in-RTL assertions hold on every cycle. They check the grant cap, that no ineligible requester is granted, that slots are gap-free and match the clear strobes in count, that the cluster strobes are one-hot, and that everything is granted when four or fewer requesters are eligible. Cycle-accurate comparison against the bench model is what shows the exact priority order, the correct slot-to-address mapping, the cluster decode of specific address values and the one-cycle latency. The bench scenarios also show a losing requester winning once higher-priority requesters withdraw, and the reset values.

// File: rtl/fwdsel_pkg.sv
package fwdsel_pkg;
  localparam int NUM_REQ     = 6;
  localparam int NUM_SLOT    = 4;
  localparam int ADDR_W      = 9;
  localparam int NUM_CLUSTER = 4;
  localparam int IDX_W       = $clog2(NUM_REQ);
  localparam int SLOT_W      = $clog2(NUM_SLOT);
  localparam int CL_W        = $clog2(NUM_CLUSTER);
  localparam int CNT_W       = $clog2(NUM_REQ + 1);

  // strobes from the picker to the address datapath
  typedef struct packed {
    logic [NUM_REQ-1:0]                 grant;
    logic [NUM_SLOT-1:0]                slotUse;
    logic [NUM_SLOT-1:0][IDX_W-1:0]     slotSrc;
  } pickStrobe_t;
endpackage

// File: rtl/fwdsel_ctrl.sv
module fwdsel_ctrl
  import fwdsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqValid,
  input  logic [NUM_REQ-1:0] reqReady,
  input  logic [NUM_REQ-1:0] reqPending,
  output pickStrobe_t        pick
);
  logic [NUM_REQ-1:0] elig;
  logic [CNT_W-1:0]   taken;

  assign elig = reqValid & reqReady & reqPending;

  // walk requesters from highest priority (index 0) down, filling slots
  always_comb begin
    pick  = '0;
    taken = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig[i] && (taken < CNT_W'(NUM_SLOT))) begin
        pick.grant[i]                         = 1'b1;
        pick.slotUse[taken[SLOT_W-1:0]]       = 1'b1;
        pick.slotSrc[taken[SLOT_W-1:0]]       = IDX_W'(i);
        taken                                 = taken + CNT_W'(1);
      end
    end
  end

  assert_grant_cap_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pick.grant) <= NUM_SLOT);

  assert_grant_elig_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pick.grant & ~(reqValid & reqReady & reqPending)) == '0);

  assert_slot_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pick.grant) == $countones(pick.slotUse));
endmodule

// File: rtl/fwdsel_dp.sv
module fwdsel_dp
  import fwdsel_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_REQ*ADDR_W-1:0]       reqAddr,
  input  pickStrobe_t                     pick,
  output logic [NUM_SLOT-1:0]             slotValid,
  output logic [NUM_SLOT*ADDR_W-1:0]      slotAddr,
  output logic [NUM_SLOT*NUM_CLUSTER-1:0] slotCluster,
  output logic [NUM_REQ-1:0]              pendClr
);
  logic [ADDR_W-1:0] addrArr [NUM_REQ];

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_unpack
    assign addrArr[r] = reqAddr[r*ADDR_W +: ADDR_W];
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic [ADDR_W-1:0]      selAddr;
    logic [NUM_CLUSTER-1:0] clNext;

    always_comb begin
      selAddr = pick.slotUse[s] ? addrArr[pick.slotSrc[s]] : '0;
      clNext  = '0;
      clNext[selAddr[ADDR_W-1 -: CL_W]] = pick.slotUse[s];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[s]                                <= 1'b0;
        slotAddr[s*ADDR_W +: ADDR_W]                <= '0;
        slotCluster[s*NUM_CLUSTER +: NUM_CLUSTER]   <= '0;
      end else begin
        slotValid[s]                                <= pick.slotUse[s];
        slotAddr[s*ADDR_W +: ADDR_W]                <= selAddr;
        slotCluster[s*NUM_CLUSTER +: NUM_CLUSTER]   <= clNext;
      end
    end

    assert_cluster_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
      $countones(slotCluster[s*NUM_CLUSTER +: NUM_CLUSTER]) == (slotValid[s] ? 1 : 0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendClr <= '0;
    else       pendClr <= pick.grant;
  end

  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid & (slotValid + 1'b1)) == '0);

  assert_clr_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pendClr) == $countones(slotValid));
endmodule

// File: rtl/fwdsel_top.sv
module fwdsel_top
  import fwdsel_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_REQ-1:0]              reqValid,
  input  logic [NUM_REQ-1:0]              reqReady,
  input  logic [NUM_REQ-1:0]              reqPending,
  input  logic [NUM_REQ*ADDR_W-1:0]       reqAddr,
  output logic [NUM_SLOT-1:0]             slotValid,
  output logic [NUM_SLOT*ADDR_W-1:0]      slotAddr,
  output logic [NUM_SLOT*NUM_CLUSTER-1:0] slotCluster,
  output logic [NUM_REQ-1:0]              pendClr
);
  pickStrobe_t pick;

  fwdsel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqPending(reqPending),
    .pick(pick)
  );

  fwdsel_dp u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .pick(pick),
    .slotValid(slotValid), .slotAddr(slotAddr),
    .slotCluster(slotCluster), .pendClr(pendClr)
  );

  logic [NUM_REQ-1:0] eligIn;
  assign eligIn = reqValid & reqReady & reqPending;

  assert_all_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(eligIn) <= NUM_SLOT) |=> (pendClr == $past(eligIn)));

  assert_clr_elig_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) or ((pendClr & ~$past(eligIn)) == '0));
endmodule

// File: tb/tb_fwdsel_top.sv
module tb_fwdsel_top;
  import fwdsel_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                            rstN;
  logic [NUM_REQ-1:0]              reqValid, reqReady, reqPending;
  logic [NUM_REQ*ADDR_W-1:0]       reqAddr;
  logic [NUM_SLOT-1:0]             slotValid;
  logic [NUM_SLOT*ADDR_W-1:0]      slotAddr;
  logic [NUM_SLOT*NUM_CLUSTER-1:0] slotCluster;
  logic [NUM_REQ-1:0]              pendClr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  fwdsel_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPending(reqPending), .reqAddr(reqAddr), .slotValid(slotValid),
    .slotAddr(slotAddr), .slotCluster(slotCluster), .pendClr(pendClr)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic setReq(int i, bit v, bit r, bit p, logic [ADDR_W-1:0] a);
    reqValid[i]   = v;
    reqReady[i]   = r;
    reqPending[i] = p;
    reqAddr[i*ADDR_W +: ADDR_W] = a;
  endtask

  // behavioural model: rank eligible requesters by index, outputs one clock later
  task automatic cycle(string tag);
    logic [NUM_SLOT-1:0]             eV = '0;
    logic [NUM_SLOT*ADDR_W-1:0]      eA = '0;
    logic [NUM_SLOT*NUM_CLUSTER-1:0] eC = '0;
    logic [NUM_REQ-1:0]              eP = '0;
    int n = 0;
    @(posedge clk);
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqValid[i] && reqReady[i] && reqPending[i] && n < NUM_SLOT) begin
        logic [ADDR_W-1:0] a = reqAddr[i*ADDR_W +: ADDR_W];
        eV[n] = 1'b1;
        eA[n*ADDR_W +: ADDR_W] = a;
        eC[n*NUM_CLUSTER + int'(a[ADDR_W-1 -: CL_W])] = 1'b1;
        eP[i] = 1'b1;
        n++;
      end
    end
    @(negedge clk);
    check({tag, "/R4"}, "slotValid",   64'(slotValid),   64'(eV));
    check({tag, "/R5"}, "slotAddr",    64'(slotAddr),    64'(eA));
    check({tag, "/R6"}, "slotCluster", 64'(slotCluster), 64'(eC));
    check({tag, "/R7"}, "pendClr",     64'(pendClr),     64'(eP));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    reqValid = '0; reqReady = '0; reqPending = '0; reqAddr = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "slotValid reset",   64'(slotValid),   64'd0);
    check("R9", "slotAddr reset",    64'(slotAddr),    64'd0);
    check("R9", "slotCluster reset", 64'(slotCluster), 64'd0);
    check("R9", "pendClr reset",     64'(pendClr),     64'd0);
    rstN = 1'b1;
    cycle("R9_idle");

    // R1: each requester missing exactly one of valid/ready/pending
    setReq(0, 0, 1, 1, 9'd5);
    setReq(1, 1, 0, 1, 9'd140);
    setReq(2, 1, 1, 0, 9'd300);
    setReq(3, 1, 1, 1, 9'd400);
    setReq(4, 0, 0, 0, 9'd7);
    setReq(5, 1, 1, 1, 9'd200);
    cycle("R1");
    check("R1", "only req3 and req5 granted", 64'(pendClr), 64'b101000);

    // R2/R3: all six eligible, four lowest indices win
    setReq(0, 1, 1, 1, 9'd10);
    setReq(1, 1, 1, 1, 9'd130);
    setReq(2, 1, 1, 1, 9'd260);
    setReq(3, 1, 1, 1, 9'd390);
    setReq(4, 1, 1, 1, 9'd131);
    setReq(5, 1, 1, 1, 9'd11);
    cycle("R3");
    check("R2", "grant count capped", 64'($countones(pendClr)), 64'd4);
    check("R3", "slot3 holds req3 addr", 64'(slotAddr[3*ADDR_W +: ADDR_W]), 64'd390);
    check("R6", "slot3 cluster M", 64'(slotCluster[12 +: 4]), 64'b1000);

    // R8: req0/req1 withdraw, losers 4 and 5 now win
    setReq(0, 0, 1, 1, 9'd10);
    setReq(1, 1, 1, 0, 9'd130);
    cycle("R8");
    check("R8", "req4 and req5 granted", 64'(pendClr), 64'b111100);

    // R4: only low-priority requesters eligible, they take slots 0 and 1
    reqValid = 6'b110000; reqReady = '1; reqPending = '1;
    cycle("R4");
    check("R4", "slot0 holds req4 addr", 64'(slotAddr[0 +: ADDR_W]), 64'd131);
    check("R4", "slots thermometer", 64'(slotValid), 64'b0011);

    // R5/R6: cluster boundaries
    reqValid = '1;
    setReq(0, 1, 1, 1, 9'd127);
    setReq(1, 1, 1, 1, 9'd128);
    setReq(2, 1, 1, 1, 9'd383);
    setReq(3, 1, 1, 1, 9'd511);
    reqValid[5:4] = 2'b00;
    cycle("R6");

    // random traffic
    for (int k = 0; k < 400; k++) begin
      reqValid   = 6'($urandom);
      reqReady   = 6'($urandom) | 6'($urandom);
      reqPending = 6'($urandom) | 6'($urandom);
      reqAddr    = {$urandom, $urandom};
      cycle("Rrand");
    end

    // R9: reset mid-stream clears outputs
    reqValid = '1; reqReady = '1; reqPending = '1;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R9", "slotValid async reset", 64'(slotValid), 64'd0);
    check("R9", "pendClr async reset", 64'(pendClr), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule